// File: doc/BRIEF.md
# Receive Message Slot Bank with FIFO Chaining

This block is the receive-side store of a message controller. It holds a bank of message slots. Each slot has an identifier filter, an identifier mask, a valid bit, a chain-continue bit, a new-data flag, a message-lost flag and a payload of identifier, length and up to eight data bytes. When the bus side presents a received frame, the block compares the frame's identifier against every valid slot. It then picks the single slot that takes the frame and stores the frame there on the next clock edge.

Consecutive slots that share one filter form a FIFO. The lowest matching slot starts the chain. The chain runs upward while the continue bit is set, and a full slot is passed over. When every slot of the chain already holds unread data, the chain's final slot is overwritten and its lost flag is raised. The host programs slots through a write port. It reads any slot through a combinational read port, and it can pulse a clear strobe to release the slot for new data. It drains a FIFO from the lowest slot number upward.

Top module: `rx_slot_bank`

## Requirements
- R1: After the asynchronous reset, every slot is invalid, and pend_o and all new-data and lost flags are zero.
- R2: A frame matches a slot only when that slot is valid and (rx_id_i AND mask) equals (filter AND mask). Mask bits that are 0 are don't-care.
- R3: Among matching slots, the lowest-numbered one heads the chain. The chain continues to the next slot only while the current slot's continue bit is 1 and the next slot also matches. So of two separate single slots with the same filter, the lower one always wins.
- R4: A frame is stored in the first chain slot, counting upward from the head, whose new-data flag is 0. Slots with the new-data flag set are skipped.
- R5: The end of a chain is a slot with its continue bit at 0, the highest slot of the bank, or a slot whose successor does not match. If the walk reaches the end slot while it still holds unread data, the frame overwrites it and that slot's lost flag becomes 1.
- R6: Storing a frame loads the slot's identifier, length and data and sets its new-data flag and its pend_o bit, all at the clock edge that samples rx_valid_i. At most one pend_o bit rises per cycle.
- R7: rd_id_o, rd_len_o, rd_data_o, rd_new_o and rd_lost_o always show the slot selected by rd_slot_i. A cycle with rd_clr_i at 1 clears that slot's new-data and lost flags at the next edge. Reading with rd_clr_i at 0 changes nothing.
- R8: A frame that matches no valid slot is dropped and changes no flag and no payload.
- R9: A configuration write loads the slot's filter, mask, continue and valid bits and clears its new-data and lost flags.
- R10: Slot selection uses the configuration and flags held before the edge. On one slot, a configuration write takes priority over a store (the frame is discarded), and a store takes priority over a read-clear (the new-data flag stays 1, and lost is set if the slot was already full).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_slot_i | input | SLOT_W | Slot being configured |
| cfg_filter_i | input | ID_W | Identifier filter value |
| cfg_mask_i | input | ID_W | Identifier mask, 1 = compare bit |
| cfg_cont_i | input | 1 | Chain-continue bit (1 on all FIFO slots but the last) |
| cfg_valid_i | input | 1 | Slot takes part in matching |
| rx_valid_i | input | 1 | Received frame present this cycle |
| rx_id_i | input | ID_W | Received identifier |
| rx_len_i | input | 4 | Received byte count (0..8) |
| rx_data_i | input | DATA_W | Received payload |
| rd_slot_i | input | SLOT_W | Slot shown on the read port |
| rd_clr_i | input | 1 | Clear new-data and lost flags of rd_slot_i |
| rd_id_o | output | ID_W | Stored identifier of the read slot |
| rd_len_o | output | 4 | Stored length of the read slot |
| rd_data_o | output | DATA_W | Stored payload of the read slot |
| rd_new_o | output | 1 | New-data flag of the read slot |
| rd_lost_o | output | 1 | Lost flag of the read slot |
| pend_o | output | NUM_SLOTS | New-data flag of every slot |

## Verification
The assertions watch several properties on every cycle. The chosen slot must match the frame. A matching lower neighbour that continues the chain must already be full. A store must set its pend bit, and an overwrite of a full slot must raise the lost flag. No pend bit may rise without a match, at most one may rise per cycle, and a clear or configuration write must drop the flag. Other behaviour can only be shown by the bench scenarios, which compare against a behavioural model on every clock. These cover the stored payload contents, the mask don't-care bits, the refill of a drained lowest slot, the end of the bank acting as a chain end, and the collision orderings between configuration, store and clear on one slot.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  localparam int unsigned LEN_W = 4;
  typedef logic [LEN_W-1:0] len_t;
endpackage

// File: rtl/rxb_match.sv
module rxb_match #(
  parameter int unsigned NUM_SLOTS = 32,
  parameter int unsigned ID_W      = 11
) (
  input  logic                            rx_valid_i,
  input  logic [ID_W-1:0]                 rx_id_i,
  input  logic [NUM_SLOTS-1:0][ID_W-1:0]  filter_i,
  input  logic [NUM_SLOTS-1:0][ID_W-1:0]  mask_i,
  input  logic [NUM_SLOTS-1:0]            valid_i,
  output logic [NUM_SLOTS-1:0]            match_o
);
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cmp
    assign match_o[g] = rx_valid_i && valid_i[g] &&
                        (((rx_id_i ^ filter_i[g]) & mask_i[g]) == '0);
  end
endmodule

// File: rtl/rxb_chain_pick.sv
module rxb_chain_pick #(
  parameter int unsigned NUM_SLOTS = 32,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS-1:0] match_i,
  input  logic [NUM_SLOTS-1:0] new_i,
  input  logic [NUM_SLOTS-1:0] cont_i,
  output logic                 hit_o,
  output logic [SLOT_W-1:0]    tgt_o
);
  logic [NUM_SLOTS-1:0] next_match;
  logic [NUM_SLOTS-1:0] stop;

  // successor match; the top slot has none, so it always ends a chain
  assign next_match = {1'b0, match_i[NUM_SLOTS-1:1]};
  assign stop       = match_i & (~new_i | ~cont_i | ~next_match);

  // first matching slot is the head; walking up through matching slots,
  // the first stop point is where the frame lands
  always_comb begin
    hit_o = 1'b0;
    tgt_o = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (!hit_o && stop[i]) begin
        hit_o = 1'b1;
        tgt_o = i[SLOT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/rxb_slot_regs.sv
module rxb_slot_regs
  import rxb_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 32,
  parameter int unsigned ID_W      = 11,
  parameter int unsigned DATA_W    = 64,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             cfg_we_i,
  input  logic [SLOT_W-1:0]                cfg_slot_i,
  input  logic [ID_W-1:0]                  cfg_filter_i,
  input  logic [ID_W-1:0]                  cfg_mask_i,
  input  logic                             cfg_cont_i,
  input  logic                             cfg_valid_i,
  input  logic                             st_hit_i,
  input  logic [SLOT_W-1:0]                st_slot_i,
  input  logic [ID_W-1:0]                  rx_id_i,
  input  len_t                             rx_len_i,
  input  logic [DATA_W-1:0]                rx_data_i,
  input  logic                             clr_i,
  input  logic [SLOT_W-1:0]                clr_slot_i,
  output logic [NUM_SLOTS-1:0][ID_W-1:0]   filter_o,
  output logic [NUM_SLOTS-1:0][ID_W-1:0]   mask_o,
  output logic [NUM_SLOTS-1:0]             cont_o,
  output logic [NUM_SLOTS-1:0]             valid_o,
  output logic [NUM_SLOTS-1:0]             new_o,
  output logic [NUM_SLOTS-1:0]             lost_o,
  output logic [NUM_SLOTS-1:0][ID_W-1:0]   id_o,
  output len_t [NUM_SLOTS-1:0]             len_o,
  output logic [NUM_SLOTS-1:0][DATA_W-1:0] data_o
);
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic wr_sel, st_sel, clr_sel;
    assign wr_sel  = cfg_we_i && (cfg_slot_i == SLOT_W'(g));
    assign st_sel  = st_hit_i && (st_slot_i == SLOT_W'(g)) && !wr_sel;
    assign clr_sel = clr_i && (clr_slot_i == SLOT_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        filter_o[g] <= '0;
        mask_o[g]   <= '0;
        cont_o[g]   <= 1'b0;
        valid_o[g]  <= 1'b0;
        new_o[g]    <= 1'b0;
        lost_o[g]   <= 1'b0;
      end else if (wr_sel) begin
        filter_o[g] <= cfg_filter_i;
        mask_o[g]   <= cfg_mask_i;
        cont_o[g]   <= cfg_cont_i;
        valid_o[g]  <= cfg_valid_i;
        new_o[g]    <= 1'b0;
        lost_o[g]   <= 1'b0;
      end else if (st_sel) begin
        new_o[g]    <= 1'b1;
        lost_o[g]   <= lost_o[g] | new_o[g];
      end else if (clr_sel) begin
        new_o[g]    <= 1'b0;
        lost_o[g]   <= 1'b0;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        id_o[g]   <= '0;
        len_o[g]  <= '0;
        data_o[g] <= '0;
      end else if (st_sel) begin
        id_o[g]   <= rx_id_i;
        len_o[g]  <= rx_len_i;
        data_o[g] <= rx_data_i;
      end
    end
  end
endmodule

// File: rtl/rx_slot_bank.sv
module rx_slot_bank
  import rxb_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 32,
  parameter int unsigned ID_W      = 11,
  parameter int unsigned DATA_W    = 64,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [SLOT_W-1:0]    cfg_slot_i,
  input  logic [ID_W-1:0]      cfg_filter_i,
  input  logic [ID_W-1:0]      cfg_mask_i,
  input  logic                 cfg_cont_i,
  input  logic                 cfg_valid_i,
  input  logic                 rx_valid_i,
  input  logic [ID_W-1:0]      rx_id_i,
  input  logic [LEN_W-1:0]     rx_len_i,
  input  logic [DATA_W-1:0]    rx_data_i,
  input  logic [SLOT_W-1:0]    rd_slot_i,
  input  logic                 rd_clr_i,
  output logic [ID_W-1:0]      rd_id_o,
  output logic [LEN_W-1:0]     rd_len_o,
  output logic [DATA_W-1:0]    rd_data_o,
  output logic                 rd_new_o,
  output logic                 rd_lost_o,
  output logic [NUM_SLOTS-1:0] pend_o
);
  logic [NUM_SLOTS-1:0][ID_W-1:0]   filter_q, mask_q, id_q;
  logic [NUM_SLOTS-1:0][DATA_W-1:0] data_q;
  len_t [NUM_SLOTS-1:0]             len_q;
  logic [NUM_SLOTS-1:0]             cont_q, valid_q, new_q, lost_q, match_w;
  logic                             hit_w;
  logic [SLOT_W-1:0]                tgt_w;

  rxb_match #(.NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W)) u_match (
    .rx_valid_i (rx_valid_i),
    .rx_id_i    (rx_id_i),
    .filter_i   (filter_q),
    .mask_i     (mask_q),
    .valid_i    (valid_q),
    .match_o    (match_w)
  );

  rxb_chain_pick #(.NUM_SLOTS(NUM_SLOTS)) u_pick (
    .match_i (match_w),
    .new_i   (new_q),
    .cont_i  (cont_q),
    .hit_o   (hit_w),
    .tgt_o   (tgt_w)
  );

  rxb_slot_regs #(.NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W), .DATA_W(DATA_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_we_i     (cfg_we_i),
    .cfg_slot_i   (cfg_slot_i),
    .cfg_filter_i (cfg_filter_i),
    .cfg_mask_i   (cfg_mask_i),
    .cfg_cont_i   (cfg_cont_i),
    .cfg_valid_i  (cfg_valid_i),
    .st_hit_i     (hit_w),
    .st_slot_i    (tgt_w),
    .rx_id_i      (rx_id_i),
    .rx_len_i     (rx_len_i),
    .rx_data_i    (rx_data_i),
    .clr_i        (rd_clr_i),
    .clr_slot_i   (rd_slot_i),
    .filter_o     (filter_q),
    .mask_o       (mask_q),
    .cont_o       (cont_q),
    .valid_o      (valid_q),
    .new_o        (new_q),
    .lost_o       (lost_q),
    .id_o         (id_q),
    .len_o        (len_q),
    .data_o       (data_q)
  );

  assign rd_id_o   = id_q[rd_slot_i];
  assign rd_len_o  = len_q[rd_slot_i];
  assign rd_data_o = data_q[rd_slot_i];
  assign rd_new_o  = new_q[rd_slot_i];
  assign rd_lost_o = lost_q[rd_slot_i];
  assign pend_o    = new_q;
endmodule

// File: rtl/rx_slot_bank_chk.sv
module rx_slot_bank_chk #(
  parameter int unsigned NUM_SLOTS = 32,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cfg_we_i,
  input logic [SLOT_W-1:0]    cfg_slot_i,
  input logic [SLOT_W-1:0]    rd_slot_i,
  input logic                 rd_clr_i,
  input logic [NUM_SLOTS-1:0] pend_o,
  input logic [NUM_SLOTS-1:0] match_w,
  input logic [NUM_SLOTS-1:0] cont_q,
  input logic [NUM_SLOTS-1:0] lost_q,
  input logic                 hit_w,
  input logic [SLOT_W-1:0]    tgt_w
);
  logic cfg_hits_tgt;
  assign cfg_hits_tgt = cfg_we_i && (cfg_slot_i == tgt_w);

  AST_TGT_MATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_w |-> match_w[tgt_w]); // R3

  AST_SKIP_ONLY_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_w && tgt_w != '0 && match_w[tgt_w - SLOT_W'(1)] && cont_q[tgt_w - SLOT_W'(1)])
      |-> pend_o[tgt_w - SLOT_W'(1)]); // R4

  AST_OVERWRITE_LOST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_w && pend_o[tgt_w] && !cfg_hits_tgt) |=> lost_q[$past(tgt_w)]); // R5

  AST_STORE_SETS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_w && !cfg_hits_tgt) |=> pend_o[$past(tgt_w)]); // R6

  AST_SINGLE_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $countones(pend_o & ~$past(pend_o)) <= 1); // R6

  AST_CLR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && !(hit_w && tgt_w == rd_slot_i)) |=> !pend_o[$past(rd_slot_i)]); // R7

  AST_NO_MATCH_NO_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_w == '0) |=> ((pend_o & ~$past(pend_o)) == '0)); // R8

  AST_CFG_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> !pend_o[$past(cfg_slot_i)]); // R9
endmodule

bind rx_slot_bank rx_slot_bank_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_we_i   (cfg_we_i),
  .cfg_slot_i (cfg_slot_i),
  .rd_slot_i  (rd_slot_i),
  .rd_clr_i   (rd_clr_i),
  .pend_o     (pend_o),
  .match_w    (match_w),
  .cont_q     (cont_q),
  .lost_q     (lost_q),
  .hit_w      (hit_w),
  .tgt_w      (tgt_w)
);

// File: tb/sim_rx_slot_bank.sv
`timescale 1ns/1ps
module sim_rx_slot_bank;
  localparam int N  = 32;
  localparam int SW = 5;
  localparam int IW = 11;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_we = 0, cfg_cont = 0, cfg_valid = 0;
  logic [SW-1:0] cfg_slot = '0, rd_slot = '0;
  logic [IW-1:0] cfg_filter = '0, cfg_mask = '0, rx_id = '0;
  logic          rx_valid = 0, rd_clr = 0;
  logic [3:0]    rx_len = '0;
  logic [DW-1:0] rx_data = '0;
  logic [IW-1:0] rd_id;
  logic [3:0]    rd_len;
  logic [DW-1:0] rd_data;
  logic          rd_new, rd_lost;
  logic [N-1:0]  pend;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rx_slot_bank u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we), .cfg_slot_i(cfg_slot), .cfg_filter_i(cfg_filter),
    .cfg_mask_i(cfg_mask), .cfg_cont_i(cfg_cont), .cfg_valid_i(cfg_valid),
    .rx_valid_i(rx_valid), .rx_id_i(rx_id), .rx_len_i(rx_len), .rx_data_i(rx_data),
    .rd_slot_i(rd_slot), .rd_clr_i(rd_clr),
    .rd_id_o(rd_id), .rd_len_o(rd_len), .rd_data_o(rd_data),
    .rd_new_o(rd_new), .rd_lost_o(rd_lost), .pend_o(pend)
  );

  // behavioural reference
  logic [IW-1:0] m_filt [N], m_mask [N], m_id [N];
  logic          m_cont [N], m_val [N], m_new [N], m_lost [N];
  logic [3:0]    m_len [N];
  logic [DW-1:0] m_data [N];

  function automatic bit m_hits(int s, logic [IW-1:0] id);
    return m_val[s] && ((id & m_mask[s]) == (m_filt[s] & m_mask[s]));
  endfunction

  function automatic int m_pick(logic [IW-1:0] id);
    int h = -1;
    for (int i = 0; i < N; i++) if (h < 0 && m_hits(i, id)) h = i;
    if (h < 0) return -1;
    while (h < N-1 && m_cont[h] && m_new[h] && m_hits(h+1, id)) h++;
    return h;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) begin
        m_filt[i] = '0; m_mask[i] = '0; m_id[i] = '0; m_cont[i] = 0; m_val[i] = 0;
        m_new[i] = 0; m_lost[i] = 0; m_len[i] = '0; m_data[i] = '0;
      end
    end else begin
      int t;
      t = rx_valid ? m_pick(rx_id) : -1;
      if (cfg_we && t == int'(cfg_slot)) t = -1;
      if (rd_clr && int'(rd_slot) != t) begin
        m_new[rd_slot] = 0; m_lost[rd_slot] = 0;
      end
      if (t >= 0) begin
        m_lost[t] = m_lost[t] | m_new[t];
        m_new[t] = 1; m_id[t] = rx_id; m_len[t] = rx_len; m_data[t] = rx_data;
      end
      if (cfg_we) begin
        m_filt[cfg_slot] = cfg_filter; m_mask[cfg_slot] = cfg_mask;
        m_cont[cfg_slot] = cfg_cont; m_val[cfg_slot] = cfg_valid;
        m_new[cfg_slot] = 0; m_lost[cfg_slot] = 0;
      end
    end
  end

  task automatic chk(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      logic [N-1:0] mp;
      for (int i = 0; i < N; i++) mp[i] = m_new[i];
      chk(pend === mp, "R6 pend vs model", DW'(pend), DW'(mp));
      if (rst_ni) begin
        chk(rd_new === m_new[rd_slot] && rd_lost === m_lost[rd_slot],
            "R7 flags vs model", {62'd0, rd_new, rd_lost}, {62'd0, m_new[rd_slot], m_lost[rd_slot]});
        chk(rd_id === m_id[rd_slot] && rd_len === m_len[rd_slot] && rd_data === m_data[rd_slot],
            "R6 payload vs model", rd_data, m_data[rd_slot]);
      end
    end
  end

  task automatic cyc();
    @(posedge clk); #2;
  endtask

  task automatic cfg(int s, logic [IW-1:0] f, logic [IW-1:0] m, bit c, bit v);
    cfg_we = 1; cfg_slot = SW'(s); cfg_filter = f; cfg_mask = m; cfg_cont = c; cfg_valid = v;
    cyc();
    cfg_we = 0;
  endtask

  task automatic frame(logic [IW-1:0] id, logic [DW-1:0] d);
    rx_valid = 1; rx_id = id; rx_len = 4'd8; rx_data = d;
    cyc();
    rx_valid = 0;
  endtask

  task automatic peek(int s);
    rd_slot = SW'(s); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk(pend === '0, "R1 reset pend", DW'(pend), 0);
    rst_ni = 1;
    cyc();
    peek(0);
    chk(rd_new === 0 && rd_lost === 0, "R1 reset flags", DW'(rd_new), 0);

    // single slot, exact filter
    cfg(5, 11'h123, 11'h7FF, 0, 1);
    frame(11'h123, 64'h1122334455667788);
    peek(5);
    chk(pend === (32'd1 << 5), "R2 single match pend", DW'(pend), 64'h20);
    chk(rd_id === 11'h123 && rd_data === 64'h1122334455667788 && rd_len === 4'd8,
        "R6 stored payload", rd_data, 64'h1122334455667788);
    frame(11'h124, 64'hDEAD);
    chk(pend === (32'd1 << 5) && rd_data === 64'h1122334455667788, "R8 no match dropped",
        rd_data, 64'h1122334455667788);

    // four-deep FIFO on slots 10..13, low nibble don't-care
    cfg(10, 11'h200, 11'h7F0, 1, 1);
    cfg(11, 11'h200, 11'h7F0, 1, 1);
    cfg(12, 11'h200, 11'h7F0, 1, 1);
    cfg(13, 11'h200, 11'h7F0, 0, 1);
    for (int k = 0; k < 4; k++) frame(11'h201 + IW'(k), 64'(k + 100));
    chk(pend[13:10] === 4'hF, "R4 chain fills in order", DW'(pend[13:10]), 64'hF);
    peek(12);
    chk(rd_id === 11'h203, "R4 third frame in slot 12", DW'(rd_id), 64'h203);
    frame(11'h20F, 64'd999);
    peek(13);
    chk(rd_id === 11'h20F && rd_lost === 1, "R5 last slot overwritten", DW'(rd_id), 64'h20F);
    peek(12);
    chk(rd_lost === 0 && rd_id === 11'h203, "R5 inner slot untouched", DW'(rd_id), 64'h203);

    // read without clear, then drain slot 10 and refill
    peek(10);
    cyc();
    chk(pend[10] === 1, "R7 read without clear keeps flag", DW'(pend[10]), 1);
    rd_clr = 1; cyc(); rd_clr = 0;
    chk(pend[10] === 0, "R7 clear releases slot", DW'(pend[10]), 0);
    frame(11'h20A, 64'd55);
    peek(10);
    chk(rd_new === 1 && rd_id === 11'h20A, "R4 refill lowest free", DW'(rd_id), 64'h20A);
    peek(13);
    rd_clr = 1; cyc(); rd_clr = 0;
    chk(rd_lost === 0 && rd_new === 0, "R7 clear drops lost", DW'(rd_lost), 0);

    // invalid slot ignored
    cfg(20, 11'h300, 11'h7FF, 0, 0);
    frame(11'h300, 64'd1);
    chk(pend[20] === 0, "R2 invalid slot ignored", DW'(pend[20]), 0);

    // two separate single slots with same filter: lower one always wins
    cfg(2, 11'h055, 11'h7FF, 0, 1);
    cfg(3, 11'h055, 11'h7FF, 0, 1);
    frame(11'h055, 64'd7);
    frame(11'h055, 64'd8);
    peek(2);
    chk(rd_data === 64'd8 && rd_lost === 1 && pend[3] === 0, "R3 lower single slot wins",
        rd_data, 64'd8);

    // top slot ends a chain even with continue set
    cfg(31, 11'h400, 11'h7FF, 1, 1);
    frame(11'h400, 64'd1);
    frame(11'h400, 64'd2);
    peek(31);
    chk(rd_data === 64'd2 && rd_lost === 1, "R5 bank top is chain end", rd_data, 64'd2);

    // store beats clear on same slot
    peek(5);
    rd_clr = 1; rx_valid = 1; rx_id = 11'h123; rx_data = 64'hABCD; rx_len = 4'd2;
    cyc();
    rd_clr = 0; rx_valid = 0;
    chk(rd_new === 1 && rd_lost === 1 && rd_data === 64'hABCD, "R10 store beats clear",
        rd_data, 64'hABCD);
    // cfg beats store on same slot
    cfg_we = 1; cfg_slot = 5; cfg_filter = 11'h123; cfg_mask = 11'h7FF; cfg_cont = 0; cfg_valid = 1;
    rx_valid = 1; rx_id = 11'h123; rx_data = 64'h5555;
    cyc();
    cfg_we = 0; rx_valid = 0;
    chk(rd_new === 0 && rd_lost === 0 && rd_data === 64'hABCD, "R10 cfg beats store",
        rd_data, 64'hABCD);
    // cfg write clears a full slot
    cfg(11, 11'h200, 11'h7F0, 1, 1);
    chk(pend[11] === 0, "R9 cfg clears flag", DW'(pend[11]), 0);
    frame(11'h20B, 64'd77);
    peek(11);
    chk(rd_new === 1 && rd_id === 11'h20B, "R9 reconfigured slot refills", DW'(rd_id), 64'h20B);

    repeat (3) cyc();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule